// File: doc/BRIEF.md
# Serial Panel Configuration Sequencer

This block brings a display controller's configuration port up and down over a write-only serial link. The host gives it one request strobe for each of four events: prepare (power-up), display on, display off and power-down. The block then plays a fixed script out of an internal table. Each script step is a register access: a command word alone, a command word with one parameter byte, or a command word with a 16-bit parameter sent high byte first. Other steps are a timed wait or an end marker.

Every word on the link is 9 bits, sent most significant bit first. Bit 8 tells the panel whether the remaining byte is a register index or parameter data. The clock idles high and the panel samples on its rising edge. Chip select stays low across one whole register access and rises between accesses. The prepare script opens with three empty commands, each followed by a wake wait measured in system clock cycles.

A fault input from the transport sets a sticky error flag. During prepare, a fault stops the script after the frame in progress. During power-down, the script still runs to its end. The busy, done and error outputs tell the host where the block stands.

Top module: `panel_cfg_sequencer`

## Requirements
- R1: Each word carries a flag in bit 8, 0 for a register index word and 1 for a parameter word, followed by the byte in bits 7:0. The first word of every access is an index word, and bits leave most significant first.
- R2: The link clock is high whenever chip select is high and after reset. MOSI changes only on a falling clock edge, so it is stable at every rising edge.
- R3: Chip select is low for exactly one access, and only while busy. The access is 9, 18 or 27 bits long, for zero, one or two parameter bytes. A 16-bit parameter is sent high byte first.
- R4: A prepare request sends, in order: index 0x00 three times; 0x17 to 0xB0; 0x80 to 0xBC; 0x00 to 0x3B; 0x16 to 0xB0; 16-bit 0xFFF9 to 0xB8; the lone command 0x11; 0x01 to 0xBA; 0x60 to 0x3A.
- R5: After each of the three opening empty commands, chip select stays high for at least WAKE_US microseconds' worth of clock cycles before the next access starts.
- R6: An on request sends the single command 0x29. An off request sends the single command 0x28.
- R7: A power-down request sends 16-bit 0x8002 to 0xB8, then the lone command 0x10, then 0x00 to 0xB0.
- R8: A fault during prepare lets the frame in progress finish. No later step runs, and done pulses with error high.
- R9: A fault during power-down does not shorten it. All three accesses go out and error is high at done.
- R10: Request strobes that arrive while busy are ignored. No second script follows.
- R11: Error is sticky through idle cycles. It is cleared only when a new request is accepted, and a fault while idle does not set it.
- R12: Done is a one-cycle pulse at the end of every script, with busy low in that cycle. After reset, busy, done and error are low and chip select is high.
- R13: When several strobes are high in the same idle cycle, the block runs exactly one script. Prepare ranks first, then on, then off, then power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_prep | input | 1 | Strobe requesting the power-up script |
| req_on | input | 1 | Strobe requesting display on |
| req_off | input | 1 | Strobe requesting display off |
| req_down | input | 1 | Strobe requesting the power-down script |
| xfer_fault | input | 1 | Transport fault indication, counted while busy |
| busy | output | 1 | A script is running |
| done | output | 1 | One-cycle pulse when a script ends |
| error | output | 1 | Sticky fault flag for the current or last script |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to the panel |
| spi_cs_n | output | 1 | Active-low chip select, framed per register access |

## Verification
Two host functions can land in the same cycle: several request strobes can arrive together, and a fault can arrive while an access is on the wire. The bench sweeps all fifteen non-empty combinations of the four strobes. For each one it decodes the link traffic and compares the frames with the script of the highest-ranked event.

For faults, the bench raises the fault during each prepare frame in turn, and during each power-down frame. It then judges the number of frames that actually left the block and the error level at the done pulse.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

   localparam int WORD_W    = 9;
   localparam int MAX_WORDS = 3;
   localparam int FRAME_W   = WORD_W * MAX_WORDS;
   localparam int EV_N      = 4;
   localparam int EV_W      = $clog2(EV_N);

   // Event order is also the priority order, index 0 ranking first.
   localparam int EV_PREP = 0;
   localparam int EV_ON   = 1;
   localparam int EV_OFF  = 2;
   localparam int EV_DOWN = 3;

   localparam int AT_PREP    = 0;
   localparam int AT_ON      = 15;
   localparam int AT_OFF     = 17;
   localparam int AT_DOWN    = 19;
   localparam int SCRIPT_LEN = 23;

   typedef enum logic [2:0] {
      STEP_CMD0,
      STEP_CMD1,
      STEP_CMD2,
      STEP_WAIT,
      STEP_END
   } step_kind_e;

   typedef struct packed {
      step_kind_e  kind;
      logic [7:0]  regno;
      logic [15:0] arg;
   } step_t;

   function automatic step_t mk_step(step_kind_e k, logic [7:0] r, logic [15:0] a);
      step_t s;
      s.kind  = k;
      s.regno = r;
      s.arg   = a;
      return s;
   endfunction

   function automatic step_t script_step(int idx);
      case (idx)
         0, 2, 4:  return mk_step(STEP_CMD0, 8'h00, 16'h0000);
         1, 3, 5:  return mk_step(STEP_WAIT, 8'h00, 16'h0000);
         6:        return mk_step(STEP_CMD1, 8'hB0, 16'h0017);
         7:        return mk_step(STEP_CMD1, 8'hBC, 16'h0080);
         8:        return mk_step(STEP_CMD1, 8'h3B, 16'h0000);
         9:        return mk_step(STEP_CMD1, 8'hB0, 16'h0016);
         10:       return mk_step(STEP_CMD2, 8'hB8, 16'hFFF9);
         11:       return mk_step(STEP_CMD0, 8'h11, 16'h0000);
         12:       return mk_step(STEP_CMD1, 8'hBA, 16'h0001);
         13:       return mk_step(STEP_CMD1, 8'h3A, 16'h0060);
         15:       return mk_step(STEP_CMD0, 8'h29, 16'h0000);
         17:       return mk_step(STEP_CMD0, 8'h28, 16'h0000);
         19:       return mk_step(STEP_CMD2, 8'hB8, 16'h8002);
         20:       return mk_step(STEP_CMD0, 8'h10, 16'h0000);
         21:       return mk_step(STEP_CMD1, 8'hB0, 16'h0000);
         default:  return mk_step(STEP_END,  8'h00, 16'h0000);
      endcase
   endfunction

   function automatic int event_base(logic [EV_W-1:0] ev);
      case (ev)
         2'd0:    return AT_PREP;
         2'd1:    return AT_ON;
         2'd2:    return AT_OFF;
         default: return AT_DOWN;
      endcase
   endfunction

endpackage

// File: rtl/panel_script_rom.sv
module panel_script_rom
   import panel_seq_pkg::*;
#(
   parameter int DEPTH = SCRIPT_LEN,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic [AW-1:0] addr_i,
   output step_t         step_o
);

   if (DEPTH < SCRIPT_LEN) begin : g_depth_chk
      $error("panel_script_rom: DEPTH smaller than the script");
   end

   step_t table_w [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      assign table_w[i] = script_step(i);
   end

   assign step_o = (int'(addr_i) < DEPTH) ? table_w[addr_i]
                                          : mk_step(STEP_END, 8'h00, 16'h0000);

endmodule

// File: rtl/panel_frame_tx.sv
module panel_frame_tx
   import panel_seq_pkg::*;
#(
   parameter int SCK_HALF = 4,
   parameter int CW       = $clog2(MAX_WORDS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [CW-1:0]      nwords_i,
   input  logic [FRAME_W-1:0] frame_i,
   output logic               fin_o,
   output logic               sclk_o,
   output logic               mosi_o,
   output logic               cs_n_o
);

   localparam int HCW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
   localparam int BW  = $clog2(FRAME_W + 1);

   if (SCK_HALF < 1) begin : g_half_chk
      $error("panel_frame_tx: SCK_HALF must be at least 1");
   end

   typedef enum logic [2:0] {TX_IDLE, TX_SETUP, TX_BITS, TX_HOLD, TX_GAP} tx_state_e;

   tx_state_e          st_q;
   logic [HCW-1:0]     hcnt_q;
   logic [BW-1:0]      left_q;
   logic [FRAME_W-1:0] sh_q;
   logic               sclk_q, mosi_q, cs_n_q, fin_q;
   logic               tick;

   assign tick = (hcnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= TX_IDLE;
         hcnt_q <= '0;
         left_q <= '0;
         sh_q   <= '0;
         sclk_q <= 1'b1;
         mosi_q <= 1'b0;
         cs_n_q <= 1'b1;
         fin_q  <= 1'b0;
      end else begin
         fin_q <= 1'b0;
         if (st_q != TX_IDLE) begin
            if (tick) hcnt_q <= HCW'(SCK_HALF - 1);
            else      hcnt_q <= hcnt_q - 1'b1;
         end
         case (st_q)
            TX_IDLE: if (start_i) begin
               cs_n_q <= 1'b0;
               sh_q   <= frame_i;
               left_q <= BW'(nwords_i) * BW'(WORD_W);
               hcnt_q <= HCW'(SCK_HALF - 1);
               st_q   <= TX_SETUP;
            end
            TX_SETUP: if (tick) begin
               sclk_q <= 1'b0;
               mosi_q <= sh_q[FRAME_W-1];
               sh_q   <= sh_q << 1;
               st_q   <= TX_BITS;
            end
            TX_BITS: if (tick) begin
               if (!sclk_q) begin
                  sclk_q <= 1'b1;
                  left_q <= left_q - 1'b1;
                  if (left_q == BW'(1)) st_q <= TX_HOLD;
               end else begin
                  sclk_q <= 1'b0;
                  mosi_q <= sh_q[FRAME_W-1];
                  sh_q   <= sh_q << 1;
               end
            end
            TX_HOLD: if (tick) begin
               cs_n_q <= 1'b1;
               st_q   <= TX_GAP;
            end
            TX_GAP: if (tick) begin
               fin_q <= 1'b1;
               st_q  <= TX_IDLE;
            end
            default: st_q <= TX_IDLE;
         endcase
      end
   end

   assign fin_o  = fin_q;
   assign sclk_o = sclk_q;
   assign mosi_o = mosi_q;
   assign cs_n_o = cs_n_q;

   AST_CLK_HIGH_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> sclk_q); // R2
   AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mosi_q) |-> $fell(sclk_q)); // R2
   AST_EDGES_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk_q) |-> !cs_n_q); // R3

endmodule

// File: rtl/panel_seq_ctrl.sv
module panel_seq_ctrl
   import panel_seq_pkg::*;
#(
   parameter int WAKE_CYC = 1000,
   parameter int AW       = $clog2(SCRIPT_LEN),
   parameter int CW       = $clog2(MAX_WORDS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EV_N-1:0]    req_i,
   input  logic               fault_i,
   output logic [AW-1:0]      addr_o,
   input  step_t              step_i,
   output logic               tx_start_o,
   output logic [CW-1:0]      tx_nwords_o,
   output logic [FRAME_W-1:0] tx_frame_o,
   input  logic               tx_fin_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o
);

   localparam int DW = $clog2(WAKE_CYC + 1);

   if (WAKE_CYC < 1) begin : g_wake_chk
      $error("panel_seq_ctrl: WAKE_CYC must be at least 1");
   end

   typedef enum logic [2:0] {S_IDLE, S_FETCH, S_SEND, S_WAIT, S_DONE} seq_state_e;

   seq_state_e         st_q;
   logic [AW-1:0]      pc_q;
   logic [EV_W-1:0]    ev_q, pick;
   logic [DW-1:0]      dly_q;
   logic               err_q, done_q, start_q;
   logic [CW-1:0]      nw_q;
   logic [FRAME_W-1:0] frame_q;
   logic               accept;

   always_comb begin
      pick = '0;
      for (int i = EV_N - 1; i >= 0; i--) begin
         if (req_i[i]) pick = EV_W'(i);
      end
   end

   assign accept = (st_q == S_IDLE) && (|req_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         pc_q    <= '0;
         ev_q    <= '0;
         dly_q   <= '0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         start_q <= 1'b0;
         nw_q    <= '0;
         frame_q <= '0;
      end else begin
         done_q  <= 1'b0;
         start_q <= 1'b0;
         if (st_q != S_IDLE && fault_i) err_q <= 1'b1;
         case (st_q)
            S_IDLE: if (accept) begin
               err_q <= 1'b0;
               ev_q  <= pick;
               pc_q  <= AW'(event_base(pick));
               st_q  <= S_FETCH;
            end
            S_FETCH: begin
               if (ev_q == EV_W'(EV_PREP) && err_q) begin
                  st_q <= S_DONE;
               end else begin
                  case (step_i.kind)
                     STEP_CMD0: begin
                        frame_q <= {1'b0, step_i.regno, 18'b0};
                        nw_q    <= CW'(1);
                        start_q <= 1'b1;
                        st_q    <= S_SEND;
                     end
                     STEP_CMD1: begin
                        frame_q <= {1'b0, step_i.regno, 1'b1, step_i.arg[7:0], 9'b0};
                        nw_q    <= CW'(2);
                        start_q <= 1'b1;
                        st_q    <= S_SEND;
                     end
                     STEP_CMD2: begin
                        frame_q <= {1'b0, step_i.regno, 1'b1, step_i.arg[15:8],
                                    1'b1, step_i.arg[7:0]};
                        nw_q    <= CW'(3);
                        start_q <= 1'b1;
                        st_q    <= S_SEND;
                     end
                     STEP_WAIT: begin
                        dly_q <= DW'(WAKE_CYC - 1);
                        st_q  <= S_WAIT;
                     end
                     default: st_q <= S_DONE;
                  endcase
               end
            end
            S_SEND: if (tx_fin_i) begin
               pc_q <= pc_q + 1'b1;
               st_q <= S_FETCH;
            end
            S_WAIT: begin
               if (dly_q == '0) begin
                  pc_q <= pc_q + 1'b1;
                  st_q <= S_FETCH;
               end else begin
                  dly_q <= dly_q - 1'b1;
               end
            end
            S_DONE: begin
               done_q <= 1'b1;
               st_q   <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign addr_o      = pc_q;
   assign tx_start_o  = start_q;
   assign tx_nwords_o = nw_q;
   assign tx_frame_o  = frame_q;
   assign busy_o      = (st_q != S_IDLE);
   assign done_o      = done_q;
   assign err_o       = err_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R12
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (st_q == S_IDLE)); // R12
   AST_EVENT_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_IDLE) |=> $stable(ev_q)); // R10
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !accept) |=> err_q); // R11
   AST_IDLE_FAULT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_q && st_q == S_IDLE) |=> !err_q); // R11

endmodule

// File: rtl/panel_cfg_sequencer.sv
module panel_cfg_sequencer
   import panel_seq_pkg::*;
#(
   parameter int CLK_HZ   = 100_000_000,
   parameter int WAKE_US  = 1000,
   parameter int SCK_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_prep,
   input  logic req_on,
   input  logic req_off,
   input  logic req_down,
   input  logic xfer_fault,
   output logic busy,
   output logic done,
   output logic error,
   output logic spi_sclk,
   output logic spi_mosi,
   output logic spi_cs_n
);

   localparam int WAKE_CYC = (CLK_HZ / 1_000_000) * WAKE_US;
   localparam int AW       = $clog2(SCRIPT_LEN);
   localparam int CW       = $clog2(MAX_WORDS + 1);

   if (CLK_HZ < 1_000_000) begin : g_clk_chk
      $error("panel_cfg_sequencer: CLK_HZ below 1 MHz gives no wake cycles");
   end

   logic [EV_N-1:0]    req_vec;
   logic [AW-1:0]      rom_addr;
   step_t              rom_step;
   logic               tx_start, tx_fin;
   logic [CW-1:0]      tx_nwords;
   logic [FRAME_W-1:0] tx_frame;

   assign req_vec = {req_down, req_off, req_on, req_prep};

   panel_script_rom #(.DEPTH(SCRIPT_LEN), .AW(AW)) u_rom (
      .addr_i (rom_addr),
      .step_o (rom_step)
   );

   panel_seq_ctrl #(.WAKE_CYC(WAKE_CYC), .AW(AW), .CW(CW)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req_vec),
      .fault_i     (xfer_fault),
      .addr_o      (rom_addr),
      .step_i      (rom_step),
      .tx_start_o  (tx_start),
      .tx_nwords_o (tx_nwords),
      .tx_frame_o  (tx_frame),
      .tx_fin_i    (tx_fin),
      .busy_o      (busy),
      .done_o      (done),
      .err_o       (error)
   );

   panel_frame_tx #(.SCK_HALF(SCK_HALF), .CW(CW)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (tx_start),
      .nwords_i (tx_nwords),
      .frame_i  (tx_frame),
      .fin_o    (tx_fin),
      .sclk_o   (spi_sclk),
      .mosi_o   (spi_mosi),
      .cs_n_o   (spi_cs_n)
   );

   AST_FRAME_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> busy); // R3
   AST_NO_START_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> spi_cs_n); // R3

endmodule

// File: tb/panel_cfg_sequencer_test.sv
module panel_cfg_sequencer_test;

   localparam int WAKE = 125;
   localparam int WD   = 190000;
   localparam int LOGN = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] req = 4'b0;
   logic fault = 1'b0;
   logic busy, done, error, sclk, mosi, cs_n;

   always #4 clk = ~clk;

   panel_cfg_sequencer #(.CLK_HZ(125_000_000), .WAKE_US(1), .SCK_HALF(2)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_prep(req[0]), .req_on(req[1]), .req_off(req[2]), .req_down(req[3]),
      .xfer_fault(fault), .busy(busy), .done(done), .error(error),
      .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n)
   );

   // link monitor: decodes frames, stamps chip select edges
   int          nfr = 0;
   int          cyc = 0;
   int          fb [LOGN];
   logic [26:0] fv [LOGN];
   int          ft [LOGN];
   int          rt [LOGN];
   int          bcnt = 0;
   logic [26:0] cur = '0;
   logic        pcs = 1'b1, psck = 1'b1;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (pcs && !cs_n) begin
            bcnt = 0; cur = '0;
            if (nfr < LOGN) ft[nfr] = cyc;
         end
         if (!cs_n && !psck && sclk) begin
            cur = {cur[25:0], mosi};
            bcnt = bcnt + 1;
         end
         if (!pcs && cs_n) begin
            if (nfr < LOGN) begin fb[nfr] = bcnt; fv[nfr] = cur; rt[nfr] = cyc; end
            nfr = nfr + 1;
         end
      end
      pcs = cs_n;
      psck = sclk;
   end

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   int          ne;
   int          eb [32];
   logic [26:0] ev [32];

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic c0(input logic [7:0] r);
      ev[ne] = {18'b0, 1'b0, r}; eb[ne] = 9; ne++;
   endtask
   task automatic c1(input logic [7:0] r, input logic [7:0] b);
      ev[ne] = {9'b0, 1'b0, r, 1'b1, b}; eb[ne] = 18; ne++;
   endtask
   task automatic c2(input logic [7:0] r, input logic [15:0] v);
      ev[ne] = {1'b0, r, 1'b1, v[15:8], 1'b1, v[7:0]}; eb[ne] = 27; ne++;
   endtask

   // event 0 prepare, 1 on, 2 off, 3 power-down (R4, R6, R7)
   task automatic exp_event(input int e);
      ne = 0;
      case (e)
         0: begin
            c0(8'h00); c0(8'h00); c0(8'h00);
            c1(8'hB0, 8'h17); c1(8'hBC, 8'h80); c1(8'h3B, 8'h00); c1(8'hB0, 8'h16);
            c2(8'hB8, 16'hFFF9); c0(8'h11); c1(8'hBA, 8'h01); c1(8'h3A, 8'h60);
         end
         1: c0(8'h29);
         2: c0(8'h28);
         default: begin c2(8'hB8, 16'h8002); c0(8'h10); c1(8'hB0, 8'h00); end
      endcase
   endtask

   task automatic start_req(input logic [3:0] r);
      @(negedge clk); req = r;
      @(negedge clk); req = 4'b0;
   endtask

   task automatic wait_done(input string rq);
      int n = 0;
      while (!done && n < 40000) begin @(negedge clk); n++; end
      chk(done == 1'b1, rq, "done pulse seen", done, 1);
      chk(busy == 1'b0, "R12", "busy low with done", busy, 0);
      @(negedge clk);
      chk(done == 1'b0, "R12", "done lasts one cycle", done, 0);
   endtask

   task automatic cmp_frames(input string rq, input int base, input int nuse);
      chk(nfr - base == nuse, rq, "frame count", nfr - base, nuse);
      for (int i = 0; i < nuse && i < nfr - base; i++) begin
         chk(fb[base+i] == eb[i] && fv[base+i] == ev[i], rq, "frame content",
             fv[base+i], ev[i]);
      end
   endtask

   task automatic inject_at(input int base, input int k);
      while (!((nfr - base == k) && !cs_n)) @(negedge clk);
      fault = 1'b1;
      @(negedge clk);
      fault = 1'b0;
   endtask

   task automatic run_all();
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state: R12, R2
      chk(busy == 0, "R12", "busy after reset", busy, 0);
      chk(done == 0, "R12", "done after reset", done, 0);
      chk(error == 0, "R12", "error after reset", error, 0);
      chk(cs_n == 1, "R12", "cs_n after reset", cs_n, 1);
      chk(sclk == 1, "R2", "sclk idle high", sclk, 1);

      // prepare script: R4, R1, R3, R5
      exp_event(0); base = nfr;
      start_req(4'b0001);
      chk(busy == 1, "R4", "busy after accept", busy, 1);
      wait_done("R4");
      cmp_frames("R4", base, ne);
      chk(error == 0, "R4", "no error", error, 0);
      for (int i = base; i < nfr; i++) begin
         chk(fb[i] == 9 || fb[i] == 18 || fb[i] == 27, "R3", "frame length", fb[i], 9);
         chk(fv[i][fb[i]-1] == 1'b0, "R1", "first word is index", fv[i][fb[i]-1], 0);
      end
      for (int i = 0; i < 3; i++) begin
         chk(ft[base+i+1] - rt[base+i] >= WAKE, "R5", "wake gap",
             ft[base+i+1] - rt[base+i], WAKE);
      end

      // on, off: R6
      exp_event(1); base = nfr; start_req(4'b0010); wait_done("R6"); cmp_frames("R6", base, ne);
      exp_event(2); base = nfr; start_req(4'b0100); wait_done("R6"); cmp_frames("R6", base, ne);

      // power-down: R7
      exp_event(3); base = nfr; start_req(4'b1000); wait_done("R7"); cmp_frames("R7", base, ne);
      chk(error == 0, "R7", "no error", error, 0);

      // requests while busy are ignored: R10
      exp_event(1); base = nfr;
      start_req(4'b0010);
      repeat (20) @(negedge clk);
      start_req(4'b1001);
      wait_done("R10");
      cmp_frames("R10", base, ne);
      repeat (300) @(negedge clk);
      chk(busy == 0, "R10", "no follow-on script", busy, 0);
      chk(nfr - base == 1, "R10", "no extra frames", nfr - base, 1);

      // all strobe combinations: R13
      for (int r = 1; r < 16; r++) begin
         int e = 0;
         while (((r >> e) & 1) == 0) e++;
         exp_event(e); base = nfr;
         start_req(4'(r));
         wait_done("R13");
         cmp_frames("R13", base, ne);
      end

      // fault during each prepare frame: R8
      for (int k = 0; k < 11; k++) begin
         exp_event(0); base = nfr;
         start_req(4'b0001);
         inject_at(base, k);
         while (!done) @(negedge clk);
         chk(error == 1, "R8", "error at done", error, 1);
         wait_done("R8");
         cmp_frames("R8", base, k + 1);
      end

      // fault during each power-down frame: R9
      for (int k = 0; k < 3; k++) begin
         exp_event(3); base = nfr;
         start_req(4'b1000);
         inject_at(base, k);
         while (!done) @(negedge clk);
         chk(error == 1, "R9", "error at done", error, 1);
         wait_done("R9");
         cmp_frames("R9", base, ne);
      end

      // sticky, cleared on accept, idle fault ignored: R11
      repeat (50) @(negedge clk);
      chk(error == 1, "R11", "error held while idle", error, 1);
      exp_event(1); base = nfr;
      start_req(4'b0010);
      chk(error == 0, "R11", "cleared on accept", error, 0);
      wait_done("R11");
      cmp_frames("R11", base, ne);
      @(negedge clk); fault = 1'b1;
      @(negedge clk); fault = 1'b0;
      repeat (5) @(negedge clk);
      chk(error == 0, "R11", "idle fault ignored", error, 0);
      chk(busy == 0, "R11", "idle fault starts nothing", busy, 0);

      finished = 1'b1;
   endtask

   initial begin
      fork
         run_all();
         begin repeat (WD) @(posedge clk); end
      join_any
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL R12 watchdog actual=hung expected=done");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule